// File: doc/BRIEF.md
# Two-Stream FP8 Widening Converter

This block takes one 8-bit floating-point operand from each of two input streams and widens both into a larger floating-point format. By default the output is IEEE half precision, and the output exponent and mantissa widths are parameters. Each stream has its own 3-bit format selector. The selector picks either a 5-bit-exponent/2-bit-mantissa encoding or a 4-bit-exponent/3-bit-mantissa encoding. Any other code is rejected and flagged as unsupported.

Each stream also has its own unsigned downscale amount, which is subtracted from the exponent of the decoded value. Stream A's amount is 7 bits wide and stream B's is 6 bits wide. Subnormal inputs are normalised first and the downscale is applied afterwards. A result that lands below the normal range of the output format is rounded to nearest-even into a subnormal or zero, and its underflow flag is raised.

The block sits behind an operand read stage. A valid strobe qualifies the inputs, and the converted words and flags appear one clock later together with an output valid strobe. Outputs hold their value on cycles without a valid input.

Top module: `fp8_wide_cvt`

## Requirements
- R1: Selector code 3'b000 decodes the byte as sign bit 7, 5-bit exponent in bits 6:2 (bias 15) and 2-bit mantissa in bits 1:0. Finite values, normal and subnormal, are converted exactly to the output format (sign bit 15, exponent 14:10 with bias 15, mantissa 9:0).
- R2: Selector code 3'b001 decodes the byte as sign bit 7, 4-bit exponent in bits 6:3 (bias 7) and 3-bit mantissa in bits 2:0. Subnormal inputs (exponent field 0) are normalised before conversion.
- R3: Selector codes 3'b010 to 3'b111 raise the stream's unsupported flag. The result is then the canonical NaN 16'h7E00 and the underflow flag is 0.
- R4: In the 3'b000 encoding, an all-ones exponent with zero mantissa gives a signed infinity (16'h7C00 or 16'hFC00). With a nonzero mantissa it gives the canonical NaN 16'h7E00.
- R5: The 3'b001 encoding has no infinity. Only byte values 8'h7F and 8'hFF are NaN and give 16'h7E00. The largest magnitude, 8'h7E = 448, gives 16'h5F00.
- R6: Stream A subtracts its 7-bit unsigned downscale from the result exponent, and stream B subtracts its own 6-bit downscale. Neither stream's controls affect the other stream.
- R7: When the downscaled exponent falls below the output's minimum normal exponent (-14), the result is the value rounded to nearest-even in output subnormal units (2^-24), which may round to zero or to the minimum normal. The stream's underflow flag is set. In every other case the underflow flag is 0.
- R8: A zero input gives a signed zero with no underflow, whatever the downscale. Infinities and NaNs also ignore the downscale.
- R9: out_valid rises exactly one cycle after in_valid and is low one cycle after a cycle without in_valid. Results and flags change only in the cycle after a valid input.
- R10: While rst_n is low, out_valid, both results and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs of this cycle are to be converted |
| a_byte | input | 8 | Stream A FP8 operand |
| b_byte | input | 8 | Stream B FP8 operand |
| a_fmt | input | 3 | Stream A format selector |
| b_fmt | input | 3 | Stream B format selector |
| a_shift | input | 7 | Stream A unsigned exponent downscale |
| b_shift | input | 6 | Stream B unsigned exponent downscale |
| out_valid | output | 1 | Results of the previous cycle's valid input |
| a_result | output | 16 | Stream A widened value |
| b_result | output | 16 | Stream B widened value |
| a_unsup | output | 1 | Stream A selector was a reserved code |
| b_unsup | output | 1 | Stream B selector was a reserved code |
| a_uflow | output | 1 | Stream A result fell below the normal range |
| b_uflow | output | 1 | Stream B result fell below the normal range |

## Verification
Every result and flag of a stream is due exactly one rising edge after the cycle in which in_valid was high, and out_valid follows in_valid with the same single-cycle delay. The bench changes inputs shortly after each rising edge. Its reference model updates on the same rising edge as the design, and design and model are compared at the next falling edge, so every comparison sees the results of exactly one earlier edge. Cycles without a valid input are compared against the model's unchanged values, which checks that the outputs hold. The bench compares zeros directly while reset is low.

// File: rtl/fp8cvt_pkg.sv
package fp8cvt_pkg;

   // Selector codes understood by the decoder; every other code is reserved.
   localparam logic [2:0] SEL_E5M2 = 3'b000;
   localparam logic [2:0] SEL_E4M3 = 3'b001;

   // Number of mantissa bits of the widest supported 8-bit encoding.
   localparam int FRAC_W = 3;

   typedef enum logic [1:0] {
      K_ZERO = 2'd0,
      K_FIN  = 2'd1,
      K_INF  = 2'd2,
      K_NAN  = 2'd3
   } fp8_kind_e;

endpackage

// File: rtl/fp8_decode.sv
module fp8_decode
   import fp8cvt_pkg::*;
#(
   parameter int EW = 10
) (
   input  logic [7:0]                   byte_i,
   input  logic [2:0]                   sel_i,
   output logic                         unsup_o,
   output logic                         sign_o,
   output fp8_kind_e                    kind_o,
   output logic signed [EW-1:0]         exp_o,
   output logic [FRAC_W-1:0]            frac_o
);

   logic              is_e5;
   logic              is_e4;
   logic [4:0]        efield;
   logic [FRAC_W-1:0] mraw;
   logic              all_ones_exp;
   logic              nan_hit;
   logic              inf_hit;

   assign is_e5   = (sel_i == SEL_E5M2);
   assign is_e4   = (sel_i == SEL_E4M3);
   assign unsup_o = !(is_e5 || is_e4);
   assign sign_o  = byte_i[7];

   // Field split: the short-mantissa encoding is left-aligned into mraw.
   always_comb begin
      if (is_e5) begin
         efield       = byte_i[6:2];
         mraw         = {byte_i[1:0], 1'b0};
         all_ones_exp = (byte_i[6:2] == 5'h1F);
         nan_hit      = all_ones_exp && (byte_i[1:0] != 2'b00);
         inf_hit      = all_ones_exp && (byte_i[1:0] == 2'b00);
      end else begin
         efield       = {1'b0, byte_i[6:3]};
         mraw         = byte_i[2:0];
         all_ones_exp = (byte_i[6:3] == 4'hF);
         nan_hit      = all_ones_exp && (byte_i[2:0] == 3'b111);
         inf_hit      = 1'b0;
      end
   end

   // Classification and normalisation of subnormal inputs.
   always_comb begin
      int bias;
      int lead;
      int e_val;
      bias   = is_e5 ? 15 : 7;
      lead   = 0;
      e_val  = 0;
      kind_o = K_ZERO;
      exp_o  = '0;
      frac_o = '0;
      if (nan_hit) begin
         kind_o = K_NAN;
      end else if (inf_hit) begin
         kind_o = K_INF;
      end else if (efield == 5'd0) begin
         if (mraw != '0) begin
            for (int k = 0; k < FRAC_W; k++) begin
               if (mraw[k]) lead = k;
            end
            e_val  = 1 - bias + lead - FRAC_W;
            kind_o = K_FIN;
            exp_o  = EW'(e_val);
            frac_o = FRAC_W'(mraw << (FRAC_W - lead));
         end
      end else begin
         e_val  = int'(efield) - bias;
         kind_o = K_FIN;
         exp_o  = EW'(e_val);
         frac_o = mraw;
      end
   end

endmodule

// File: rtl/fp8_pack.sv
module fp8_pack
   import fp8cvt_pkg::*;
#(
   parameter int OE   = 5,
   parameter int OM   = 10,
   parameter int DS_W = 7,
   parameter int EW   = 10
) (
   input  logic                 unsup_i,
   input  logic                 sign_i,
   input  fp8_kind_e            kind_i,
   input  logic signed [EW-1:0] exp_i,
   input  logic [FRAC_W-1:0]    frac_i,
   input  logic [DS_W-1:0]      shamt_i,
   output logic [OE+OM:0]       word_o,
   output logic                 uflow_o
);

   localparam int OW    = 1 + OE + OM;
   localparam int OBIAS = (2 ** (OE - 1)) - 1;
   localparam int W     = OM + 1;
   localparam int XW    = 2 * W + 1;
   localparam int SHW   = $clog2(W + 2);
   localparam logic signed [EW-1:0] EMIN_V = EW'(1 - OBIAS);
   localparam logic signed [EW-1:0] BIAS_V = EW'(OBIAS);
   localparam logic signed [EW-1:0] SHCAP_V = EW'(W + 1);
   localparam logic [OW-1:0] NAN_W = {1'b0, {OE{1'b1}}, 1'b1, {(OM-1){1'b0}}};

   logic signed [EW-1:0] er;
   logic signed [EW-1:0] deficit;
   logic                 tiny;
   logic [SHW-1:0]       sh;
   logic [W-1:0]         sig;
   logic [XW-1:0]        ext_sh;
   logic [W-1:0]         q;
   logic                 g;
   logic                 st;
   logic [W-1:0]         m;

   // Downscale, then test the result against the minimum normal exponent.
   assign er      = exp_i - $signed({{(EW-DS_W){1'b0}}, shamt_i});
   assign tiny    = (er < EMIN_V);
   assign deficit = EMIN_V - er;
   assign sh      = (deficit > SHCAP_V) ? SHW'(W + 1) : deficit[SHW-1:0];

   // Denormalising right shift with guard and sticky, round to nearest-even.
   assign sig    = {1'b1, frac_i, {(OM-FRAC_W){1'b0}}};
   assign ext_sh = {sig, {(W+1){1'b0}}} >> sh;
   assign q      = ext_sh[XW-1:W+1];
   assign g      = ext_sh[W];
   assign st     = |ext_sh[W-1:0];
   assign m      = q + W'(g & (st | q[0]));

   always_comb begin
      word_o  = '0;
      uflow_o = 1'b0;
      if (unsup_i) begin
         word_o = NAN_W;
      end else begin
         unique case (kind_i)
            K_NAN:  word_o = NAN_W;
            K_INF:  word_o = {sign_i, {OE{1'b1}}, {OM{1'b0}}};
            K_ZERO: word_o = {sign_i, {(OE+OM){1'b0}}};
            default: begin
               if (tiny) begin
                  // A carry out of m lands in the exponent LSB: minimum normal.
                  word_o  = {sign_i, {(OE+OM-W){1'b0}}, m};
                  uflow_o = 1'b1;
               end else begin
                  word_o = {sign_i, OE'(er + BIAS_V), frac_i, {(OM-FRAC_W){1'b0}}};
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/fp8_lane.sv
module fp8_lane
   import fp8cvt_pkg::*;
#(
   parameter int OE   = 5,
   parameter int OM   = 10,
   parameter int DS_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [7:0]         byte_i,
   input  logic [2:0]         sel_i,
   input  logic [DS_W-1:0]    shamt_i,
   output logic [OE+OM:0]     result_q,
   output logic               unsup_q,
   output logic               uflow_q
);

   localparam int OW = 1 + OE + OM;
   localparam int EW = ((OE > DS_W) ? OE : DS_W) + 3;
   localparam logic [OW-1:0]   NAN_W   = {1'b0, {OE{1'b1}}, 1'b1, {(OM-1){1'b0}}};
   localparam logic [OW-2:0]   INF_MAG = {{OE{1'b1}}, {OM{1'b0}}};

   logic                 d_unsup;
   logic                 d_sign;
   fp8_kind_e            d_kind;
   logic signed [EW-1:0] d_exp;
   logic [FRAC_W-1:0]    d_frac;
   logic [OW-1:0]        p_word;
   logic                 p_uflow;

   fp8_decode #(.EW(EW)) u_dec (
      .byte_i  (byte_i),
      .sel_i   (sel_i),
      .unsup_o (d_unsup),
      .sign_o  (d_sign),
      .kind_o  (d_kind),
      .exp_o   (d_exp),
      .frac_o  (d_frac)
   );

   fp8_pack #(.OE(OE), .OM(OM), .DS_W(DS_W), .EW(EW)) u_pack (
      .unsup_i (d_unsup),
      .sign_i  (d_sign),
      .kind_i  (d_kind),
      .exp_i   (d_exp),
      .frac_i  (d_frac),
      .shamt_i (shamt_i),
      .word_o  (p_word),
      .uflow_o (p_uflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         unsup_q  <= 1'b0;
         uflow_q  <= 1'b0;
      end else if (load_i) begin
         result_q <= p_word;
         unsup_q  <= d_unsup;
         uflow_q  <= p_uflow;
      end
   end

   // R3: reserved selector codes give the flag and canonical NaN.
   a_r3_reserved_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (sel_i > SEL_E4M3)) |=> (unsup_q && !uflow_q && (result_q == NAN_W)));

   // R5: the 4/3 encoding never produces an infinity.
   a_r5_no_inf: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (sel_i == SEL_E4M3)) |=> (result_q[OW-2:0] != INF_MAG));

   // R8: zero inputs stay signed zero without underflow.
   a_r8_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (sel_i <= SEL_E4M3) && (byte_i[6:0] == 7'd0))
      |=> ((result_q == {$past(byte_i[7]), {(OW-1){1'b0}}}) && !uflow_q));

   // R7: an underflowed result is subnormal or at most the minimum normal.
   a_r7_tiny_range: assert property (@(posedge clk) disable iff (!rst_n)
      uflow_q |-> (result_q[OW-2:OM] <= OE'(1)));

   // R9: without a load nothing changes.
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(result_q) && $stable(unsup_q) && $stable(uflow_q)));

endmodule

// File: rtl/fp8_wide_cvt.sv
module fp8_wide_cvt
   import fp8cvt_pkg::*;
#(
   parameter int OUT_EXP_W = 5,
   parameter int OUT_MAN_W = 10,
   parameter int A_DS_W    = 7,
   parameter int B_DS_W    = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [7:0]                     a_byte,
   input  logic [7:0]                     b_byte,
   input  logic [2:0]                     a_fmt,
   input  logic [2:0]                     b_fmt,
   input  logic [A_DS_W-1:0]              a_shift,
   input  logic [B_DS_W-1:0]              b_shift,
   output logic                           out_valid,
   output logic [OUT_EXP_W+OUT_MAN_W:0]   a_result,
   output logic [OUT_EXP_W+OUT_MAN_W:0]   b_result,
   output logic                           a_unsup,
   output logic                           b_unsup,
   output logic                           a_uflow,
   output logic                           b_uflow
);

   localparam int OW     = 1 + OUT_EXP_W + OUT_MAN_W;
   localparam int LANES  = 2;
   localparam int DS_MAX = (A_DS_W > B_DS_W) ? A_DS_W : B_DS_W;

   // Elaboration checks: the output must hold every input value unrounded
   // when no downscale is applied, and downscale fields must exist.
   if (OUT_EXP_W < 5) begin : g_bad_exp
      $error("OUT_EXP_W must be at least 5");
   end
   if (OUT_MAN_W < FRAC_W + 1) begin : g_bad_man
      $error("OUT_MAN_W must exceed the widest FP8 mantissa");
   end
   if (A_DS_W < 1 || B_DS_W < 1) begin : g_bad_ds
      $error("downscale widths must be positive");
   end

   logic [LANES-1:0][7:0]        byte_v;
   logic [LANES-1:0][2:0]        sel_v;
   logic [LANES-1:0][DS_MAX-1:0] shamt_v;
   logic [LANES-1:0][OW-1:0]     res_v;
   logic [LANES-1:0]             unsup_v;
   logic [LANES-1:0]             uflow_v;

   assign byte_v[0]  = a_byte;
   assign byte_v[1]  = b_byte;
   assign sel_v[0]   = a_fmt;
   assign sel_v[1]   = b_fmt;
   assign shamt_v[0] = DS_MAX'(a_shift);
   assign shamt_v[1] = DS_MAX'(b_shift);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fp8_lane #(.OE(OUT_EXP_W), .OM(OUT_MAN_W), .DS_W(DS_MAX)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_i   (in_valid),
         .byte_i   (byte_v[i]),
         .sel_i    (sel_v[i]),
         .shamt_i  (shamt_v[i]),
         .result_q (res_v[i]),
         .unsup_q  (unsup_v[i]),
         .uflow_q  (uflow_v[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign a_result = res_v[0];
   assign b_result = res_v[1];
   assign a_unsup  = unsup_v[0];
   assign b_unsup  = unsup_v[1];
   assign a_uflow  = uflow_v[0];
   assign b_uflow  = uflow_v[1];

   // R9: single-cycle latency of the valid strobe.
   a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

endmodule

// File: tb/fp8_wide_cvt_tb.sv
module fp8_wide_cvt_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  a_byte = '0;
   logic [7:0]  b_byte = '0;
   logic [2:0]  a_fmt = '0;
   logic [2:0]  b_fmt = '0;
   logic [6:0]  a_shift = '0;
   logic [5:0]  b_shift = '0;
   logic        out_valid;
   logic [15:0] a_result;
   logic [15:0] b_result;
   logic        a_unsup;
   logic        b_unsup;
   logic        a_uflow;
   logic        b_uflow;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fp8_wide_cvt dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_byte(a_byte), .b_byte(b_byte), .a_fmt(a_fmt), .b_fmt(b_fmt),
      .a_shift(a_shift), .b_shift(b_shift), .out_valid(out_valid),
      .a_result(a_result), .b_result(b_result), .a_unsup(a_unsup),
      .b_unsup(b_unsup), .a_uflow(a_uflow), .b_uflow(b_uflow)
   );

   // Behavioural reference: value = M * 2^X, then encode into half precision.
   function automatic void ref_cvt(input logic [7:0] b, input logic [2:0] f, input int ds,
                                   output logic [15:0] r, output bit uf, output bit us);
      int e, m, mm, x, msb, ee, q, sh, rem, half;
      bit s;
      s = b[7]; uf = 0; us = 0; r = 16'h0000;
      if (f > 3'd1) begin us = 1; r = 16'h7E00; return; end
      if (f == 3'd0) begin
         e = int'(b[6:2]); m = int'(b[1:0]);
         if (e == 31) begin r = (m == 0) ? {s, 15'h7C00} : 16'h7E00; return; end
         if (e == 0) begin mm = m; x = -16; end else begin mm = 4 + m; x = e - 17; end
      end else begin
         e = int'(b[6:3]); m = int'(b[2:0]);
         if (e == 15 && m == 7) begin r = 16'h7E00; return; end
         if (e == 0) begin mm = m; x = -9; end else begin mm = 8 + m; x = e - 10; end
      end
      if (mm == 0) begin r = {s, 15'd0}; return; end
      x = x - ds;
      msb = 0;
      for (int k = 0; k < 5; k++) if (((mm >> k) & 1) == 1) msb = k;
      ee = x + msb;
      if (ee >= -14) begin
         r = {s, 5'(ee + 15), 10'((mm << (10 - msb)) & 32'h3FF)};
      end else begin
         uf = 1;
         if (x + 24 >= 0) q = mm << (x + 24);
         else begin
            sh = -(x + 24);
            if (sh > 8) q = 0;
            else begin
               q = mm >> sh;
               rem = mm & ((1 << sh) - 1);
               half = 1 << (sh - 1);
               if (rem > half || (rem == half && (q % 2) == 1)) q = q + 1;
            end
         end
         r = {s, 15'(q)};
      end
   endfunction

   function automatic string tag_of(input logic [7:0] b, input logic [2:0] f, input int ds, input bit uf);
      if (f > 3'd1) return "R3";
      if (b[6:0] == 7'd0) return "R8";
      if (f == 3'd0 && b[6:2] == 5'h1F) return "R4";
      if (f == 3'd1 && b[6:1] == 6'h3F) return "R5";
      if (uf) return "R7";
      if (ds != 0) return "R6";
      return (f == 3'd0) ? "R1" : "R2";
   endfunction

   // Model state, updated on the same edge as the design.
   logic        m_valid;
   logic [15:0] m_ar, m_br;
   bit          m_aus, m_bus, m_auf, m_buf;
   string       m_atag = "R10", m_btag = "R10";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0; m_ar <= '0; m_br <= '0;
         m_aus <= 0; m_bus <= 0; m_auf <= 0; m_buf <= 0;
         m_atag <= "R10"; m_btag <= "R10";
      end else begin
         m_valid <= in_valid;
         if (in_valid) begin
            logic [15:0] r; bit uf, us;
            ref_cvt(a_byte, a_fmt, int'(a_shift), r, uf, us);
            m_ar <= r; m_auf <= uf; m_aus <= us;
            m_atag <= tag_of(a_byte, a_fmt, int'(a_shift), uf);
            ref_cvt(b_byte, b_fmt, int'(b_shift), r, uf, us);
            m_br <= r; m_buf <= uf; m_bus <= us;
            m_btag <= tag_of(b_byte, b_fmt, int'(b_shift), uf);
         end else begin
            m_atag <= "R9"; m_btag <= "R9";
         end
      end
   end

   task automatic check18(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp_v);
      compared++;
      if (act !== exp_v) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp_v, $time);
      end
   endtask

   // Compare on every falling edge.
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check18("R10", "reset outputs",
                    {out_valid, a_result, a_unsup, b_result, b_unsup, a_uflow, b_uflow} == '0 ? 18'd0 : 18'd1,
                    18'd0);
         end else begin
            check18("R9", "out_valid", {17'd0, out_valid}, {17'd0, m_valid});
            check18(m_atag, "stream A {result,unsup,uflow}", {a_result, a_unsup, a_uflow}, {m_ar, m_aus, m_auf});
            check18(m_btag, "stream B {result,unsup,uflow}", {b_result, b_unsup, b_uflow}, {m_br, m_bus, m_buf});
         end
      end
   end

   task automatic drive(input bit v, input logic [7:0] ab, input logic [7:0] bb,
                        input logic [2:0] af, input logic [2:0] bf,
                        input logic [6:0] ash, input logic [5:0] bsh);
      @(posedge clk); #2;
      in_valid = v; a_byte = ab; b_byte = bb; a_fmt = af; b_fmt = bf;
      a_shift = ash; b_shift = bsh;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         compared++; mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1/R2/R4/R5: every byte in both encodings, no downscale.
      for (int i = 0; i < 256; i++) drive(1, 8'(i), 8'(i), 3'd0, 3'd1, 7'd0, 6'd0);
      for (int i = 0; i < 256; i++) drive(1, 8'(i), 8'(i), 3'd1, 3'd0, 7'd0, 6'd0);
      // R3: reserved selector codes on both streams.
      for (int f = 2; f < 8; f++) drive(1, 8'h3C, 8'h45, 3'(f), 3'(9 - f), 7'd3, 6'd3);
      // R6/R7/R8: downscale sweeps with 1.0, a rounding pattern and zeros.
      for (int d = 0; d < 128; d++) drive(1, 8'h3C, 8'h38, 3'd0, 3'd1, 7'(d), 6'(d));
      for (int d = 0; d < 64; d++) drive(1, 8'h7B, 8'h3F, 3'd0, 3'd1, 7'(d), 6'(63 - d));
      for (int d = 0; d < 8; d++) drive(1, 8'h80, 8'h00, 3'd0, 3'd1, 7'(d * 16), 6'(d * 8));
      drive(1, 8'hFC, 8'h7F, 3'd0, 3'd1, 7'd90, 6'd40);
      // R9: idle cycles with changing inputs must not move outputs.
      for (int i = 0; i < 20; i++) drive(0, 8'($urandom), 8'($urandom), 3'd0, 3'd1, 7'd1, 6'd1);
      // Mixed random traffic.
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] fa, fb;
         fa = ($urandom % 8 < 6) ? 3'($urandom % 2) : 3'($urandom);
         fb = ($urandom % 8 < 6) ? 3'($urandom % 2) : 3'($urandom);
         drive(($urandom % 4) != 0, 8'($urandom), 8'($urandom), fa, fb,
               7'($urandom % 32), 6'($urandom % 32));
      end
      // R10: reset in the middle of traffic.
      drive(1, 8'h3C, 8'h38, 3'd0, 3'd1, 7'd0, 6'd0);
      @(posedge clk); #2 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1; in_valid = 1'b0;
      drive(1, 8'hC0, 8'hB8, 3'd0, 3'd1, 7'd2, 6'd1);
      drive(0, 8'h00, 8'h00, 3'd0, 3'd0, 7'd0, 6'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 done = 1'b1;
      summary();
      $finish;
   end

endmodule